// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 32 interrupt inputs and presents a single active-low request line to a processor. Every input has its own word-wide control register. That register chooses how the input is detected (high level, low level, rising edge or falling edge) and gives the input a 3-bit priority. Enable bits are not written directly. Software sets them by writing ones to one command word and clears them by writing ones to another. Two further command words let software raise a pending event or drop it.

When at least one enabled source is pending, the controller chooses a winner. The winner is the source with the highest priority value, and a tie goes to the lowest source number. The controller then pulls the request line low. The interrupt handler reads the encoding word, which returns the winner's number multiplied by four. That read acknowledges the event and releases the request line. While the handler runs, the line stays quiet. A write to the end-of-service word closes the handshake. If anything enabled is still pending at that point, the line drops again in the next cycle.

Top module: `vic_core`

## Requirements
- R1: After reset the request output `irq_n` is high, the enable word (offset 0x114) reads 0, and every control word reads 0x40 (high-level trigger, priority 0).
- R2: The control word of source n sits at byte offset 4*n. Bits [7:6] hold the trigger type and bits [2:0] hold the priority. All other bits read back as 0.
- R3: A write to offset 0x120 enables every source whose data bit is 1. A write to offset 0x124 disables every source whose data bit is 1. Sources whose data bit is 0 keep their setting. The enable word reads at 0x114.
- R4: Trigger type 1 makes a source pending while its input is 1. Type 0 makes it pending while its input is 0. The inputs read at 0x100, the pending bits at 0x104, and pending-and-enabled at 0x108.
- R5: Trigger type 3 latches pending on a 0-to-1 input change. Type 2 latches pending on a 1-to-0 change. The latch holds after the input returns to its idle level and clears when the source is acknowledged.
- R6: Among enabled pending sources, the highest priority value wins. Equal priorities go to the lower source number.
- R7: A read of offset 0x10C returns the winner's number times 4, and offset 0x110 returns the number itself. A read of 0x10C while `irq_n` is low acknowledges that source and sets `irq_n` high after the next clock edge.
- R8: After an acknowledge, `irq_n` stays high until any write to offset 0x130. If an enabled source is still pending, `irq_n` is low right after the clock edge that takes that write. A write to 0x130 outside service has no effect.
- R9: Writing ones to offset 0x128 makes those sources pending. Writing ones to offset 0x12C clears their latched pending state.
- R10: A pending source that is not enabled shows in 0x104 but not in 0x108, and it never pulls `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 32 | Interrupt inputs, synchronous to clk |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench checks that the request line stays high throughout service even while a level source is still held. A design that re-armed on its own would raise a second request before end-of-service. It then writes end-of-service with that level still active and expects the line low in the very next cycle. A design that waited an extra arbitration cycle fails here. Ties are tested with two equal-priority sources set in one write: the lower number must be served first, and a higher-priority source that arrives while the line is already low must displace the pending winner. Edge sources must remain pending after the input returns to its idle level and must clear on acknowledge. Disabled sources must show in the pending word but never reach the request line.

// File: rtl/vic_pkg.sv
// vic_pkg: shared types and register offsets of the interrupt controller.
// Assumes a 12-bit byte address and word-aligned accesses.
package vic_pkg;

    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_RISE = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        SVC_IDLE = 2'd0,
        SVC_REQ  = 2'd1,
        SVC_BUSY = 2'd2
    } svc_e;

    localparam logic [ADDR_W-1:0] OFS_RAW  = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_PEND = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_ENC  = 12'h10C;
    localparam logic [ADDR_W-1:0] OFS_NUM  = 12'h110;
    localparam logic [ADDR_W-1:0] OFS_MASK = 12'h114;
    localparam logic [ADDR_W-1:0] OFS_MEN  = 12'h120;
    localparam logic [ADDR_W-1:0] OFS_MDIS = 12'h124;
    localparam logic [ADDR_W-1:0] OFS_SET  = 12'h128;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 12'h12C;
    localparam logic [ADDR_W-1:0] OFS_EOS  = 12'h130;

endpackage

// File: rtl/vic_src_cell.sv
// vic_src_cell: one interrupt source. Holds the trigger type and priority,
// detects level or edge events, and keeps the latched pending bit.
// Assumes pin is already synchronous to clk.
module vic_src_cell #(
    parameter int PRI_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_trig,
    input  logic [PRI_W-1:0]  cfg_pri,
    input  logic              sw_set,
    input  logic              sw_clr,
    input  logic              ack,
    output vic_pkg::trig_e    trig_q,
    output logic [PRI_W-1:0]  pri_q,
    output logic              pend
);
    import vic_pkg::*;

    logic pin_d;
    logic latch_q;
    logic edge_hit;
    logic level_hit;

    // Configuration register: trigger type and priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= TRIG_HIGH;
            pri_q  <= '0;
        end else if (cfg_we) begin
            trig_q <= trig_e'(cfg_trig);
            pri_q  <= cfg_pri;
        end
    end

    // Previous input sample, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_d <= 1'b0;
        else        pin_d <= pin;
    end

    // Decode edge and level events from the selected trigger type.
    always_comb begin
        edge_hit  = ((trig_q == TRIG_RISE) &&  pin && !pin_d) ||
                    ((trig_q == TRIG_FALL) && !pin &&  pin_d);
        level_hit = ((trig_q == TRIG_HIGH) &&  pin) ||
                    ((trig_q == TRIG_LOW)  && !pin);
    end

    // Latched pending: a new event wins over acknowledge or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                latch_q <= 1'b0;
        else if (edge_hit || sw_set) latch_q <= 1'b1;
        else if (ack || sw_clr)      latch_q <= 1'b0;
    end

    // Pending while latched or while the active level is held.
    always_comb pend = latch_q | level_hit;

endmodule

// File: rtl/vic_prio_pick.sv
// vic_prio_pick: picks the eligible source with the highest priority value;
// equal priorities go to the lower index. Purely combinational.
module vic_prio_pick #(
    parameter int NUM_SRC = 32,
    parameter int PRI_W   = 3,
    parameter int ID_W    = 5
) (
    input  logic [NUM_SRC-1:0]            elig,
    input  logic [NUM_SRC-1:0][PRI_W-1:0] pri,
    output logic                          any,
    output logic [ID_W-1:0]               win_id
);
    logic [PRI_W-1:0] best_pri;

    // Scan from the top index down; '>=' lets lower indices take ties.
    always_comb begin
        any      = 1'b0;
        best_pri = '0;
        win_id   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i] && (!any || (pri[i] >= best_pri))) begin
                any      = 1'b1;
                best_pri = pri[i];
                win_id   = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/vic_svc_fsm.sv
// vic_svc_fsm: request and service handshake. Raises the request when an
// eligible source exists, acknowledges on the encoding read, and waits for
// end-of-service before raising again.
module vic_svc_fsm #(
    parameter int ID_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            elig_any,
    input  logic [ID_W-1:0] win_id,
    input  logic            enc_rd,
    input  logic            eos_wr,
    output logic            irq_n,
    output logic            in_service,
    output logic            ack_go,
    output logic [ID_W-1:0] cur_id
);
    import vic_pkg::*;

    svc_e state_q;

    // State and captured winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SVC_IDLE;
            cur_id  <= '0;
        end else begin
            case (state_q)
                SVC_IDLE: begin
                    if (elig_any) begin
                        state_q <= SVC_REQ;
                        cur_id  <= win_id;
                    end
                end
                SVC_REQ: begin
                    if (enc_rd)        state_q <= SVC_BUSY;
                    else if (elig_any) cur_id  <= win_id;
                    else               state_q <= SVC_IDLE;
                end
                SVC_BUSY: begin
                    if (eos_wr) begin
                        if (elig_any) begin
                            state_q <= SVC_REQ;
                            cur_id  <= win_id;
                        end else begin
                            state_q <= SVC_IDLE;
                        end
                    end
                end
                default: state_q <= SVC_IDLE;
            endcase
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        irq_n      = (state_q != SVC_REQ);
        in_service = (state_q == SVC_BUSY);
        ack_go     = (state_q == SVC_REQ) && enc_rd;
    end

endmodule

// File: rtl/vic_core.sv
// vic_core: top of the interrupt controller. Decodes the register space,
// instantiates one cell per source, the arbiter and the handshake FSM.
// Assumes single-cycle accesses and NUM_SRC <= DATA_W, PRI_W <= 3.
module vic_core #(
    parameter int NUM_SRC = 32,
    parameter int PRI_W   = 3,
    parameter int DATA_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_in,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [vic_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       irq_n
);
    import vic_pkg::*;

    localparam int ID_W      = $clog2(NUM_SRC);
    localparam int CTRL_SPAN = NUM_SRC * 4;

    logic                          wr_en, rd_en;
    logic                          ctrl_hit;
    logic [ID_W-1:0]               ctrl_idx;
    logic [NUM_SRC-1:0]            mask_q;
    logic [NUM_SRC-1:0]            pend;
    logic [NUM_SRC-1:0]            elig;
    logic [NUM_SRC-1:0]            ack_vec;
    trig_e                         trig_arr [NUM_SRC];
    logic [NUM_SRC-1:0][PRI_W-1:0] pri_arr;
    logic                          elig_any;
    logic [ID_W-1:0]               win_id;
    logic [ID_W-1:0]               cur_id;
    logic                          enc_rd, eos_wr, ack_go, in_service;
    logic                          set_wr, clr_wr, men_wr, mdis_wr;

    // Access decode.
    always_comb begin
        wr_en    = bus_sel && bus_wr;
        rd_en    = bus_sel && !bus_wr;
        ctrl_hit = (bus_addr[1:0] == 2'b00) && (32'(bus_addr) < CTRL_SPAN);
        ctrl_idx = bus_addr[ID_W+1:2];
        enc_rd   = rd_en && (bus_addr == OFS_ENC);
        eos_wr   = wr_en && (bus_addr == OFS_EOS);
        set_wr   = wr_en && (bus_addr == OFS_SET);
        clr_wr   = wr_en && (bus_addr == OFS_CLR);
        men_wr   = wr_en && (bus_addr == OFS_MEN);
        mdis_wr  = wr_en && (bus_addr == OFS_MDIS);
    end

    // Enable word, changed only by the set/clear command words.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (men_wr)  mask_q <= mask_q | bus_wdata[NUM_SRC-1:0];
        else if (mdis_wr) mask_q <= mask_q & ~bus_wdata[NUM_SRC-1:0];
    end

    // One detection cell per source.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        always_comb ack_vec[g] = ack_go && (cur_id == ID_W'(g));

        vic_src_cell #(.PRI_W(PRI_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (src_in[g]),
            .cfg_we   (wr_en && ctrl_hit && (ctrl_idx == ID_W'(g))),
            .cfg_trig (bus_wdata[7:6]),
            .cfg_pri  (bus_wdata[PRI_W-1:0]),
            .sw_set   (set_wr && bus_wdata[g]),
            .sw_clr   (clr_wr && bus_wdata[g]),
            .ack      (ack_vec[g]),
            .trig_q   (trig_arr[g]),
            .pri_q    (pri_arr[g]),
            .pend     (pend[g])
        );
    end

    // Only enabled sources take part in arbitration.
    always_comb elig = pend & mask_q;

    vic_prio_pick #(.NUM_SRC(NUM_SRC), .PRI_W(PRI_W), .ID_W(ID_W)) u_pick (
        .elig   (elig),
        .pri    (pri_arr),
        .any    (elig_any),
        .win_id (win_id)
    );

    vic_svc_fsm #(.ID_W(ID_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .elig_any   (elig_any),
        .win_id     (win_id),
        .enc_rd     (enc_rd),
        .eos_wr     (eos_wr),
        .irq_n      (irq_n),
        .in_service (in_service),
        .ack_go     (ack_go),
        .cur_id     (cur_id)
    );

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit) begin
            bus_rdata[7:6]       = trig_arr[ctrl_idx];
            bus_rdata[PRI_W-1:0] = pri_arr[ctrl_idx];
        end else begin
            case (bus_addr)
                OFS_RAW:  bus_rdata = DATA_W'(src_in);
                OFS_PEND: bus_rdata = DATA_W'(pend);
                OFS_STAT: bus_rdata = DATA_W'(elig);
                OFS_ENC:  bus_rdata = DATA_W'({cur_id, 2'b00});
                OFS_NUM:  bus_rdata = DATA_W'(cur_id);
                OFS_MASK: bus_rdata = DATA_W'(mask_q);
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/vic_core_chk.sv
// vic_core_chk: protocol checks for vic_core, attached with bind.
module vic_core_chk #(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic [vic_pkg::ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic                       irq_n,
    input logic [NUM_SRC-1:0]         mask_q,
    input logic                       elig_any,
    input logic                       in_service
);
    import vic_pkg::*;

    logic                 men_w, mdis_w, enc_r, eos_w;
    logic [NUM_SRC-1:0]   wd;

    // Local decode of the accesses the properties refer to.
    always_comb begin
        men_w  = bus_sel && bus_wr && (bus_addr == OFS_MEN);
        mdis_w = bus_sel && bus_wr && (bus_addr == OFS_MDIS);
        eos_w  = bus_sel && bus_wr && (bus_addr == OFS_EOS);
        enc_r  = bus_sel && !bus_wr && (bus_addr == OFS_ENC);
        wd     = bus_wdata[NUM_SRC-1:0];
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> irq_n);

    assert_mask_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        men_w |=> ((mask_q & $past(wd)) == $past(wd)));

    assert_mask_disable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mdis_w |=> ((mask_q & $past(wd)) == '0));

    assert_ack_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_r && !irq_n) |=> irq_n);

    assert_quiet_in_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && !eos_w) |=> irq_n);

    assert_eos_reraise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && eos_w && elig_any) |=> !irq_n);

    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && !in_service && !elig_any) |=> irq_n);

endmodule

bind vic_core vic_core_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq_n      (irq_n),
    .mask_q     (mask_q),
    .elig_any   (elig_any),
    .in_service (in_service)
);

// File: tb/vic_core_test.sv
module vic_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_n;

    always #2 clk = ~clk;

    vic_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    event        obs_ev;
    logic [31:0] obs_val;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;

    // Monitor: pops one expected item per observation and compares.
    initial begin
        forever begin
            @(obs_ev);
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: actual %h expected none", obs_val);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (obs_val !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, obs_val, it.exp);
                end
            end
        end
    end

    task automatic push_exp(input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic read_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        push_exp(e, tag);
        obs_val = bus_rdata;
        -> obs_ev;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        push_exp({31'b0, e}, tag);
        obs_val = {31'b0, irq_n};
        -> obs_ev;
        #0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(input int k, input logic v);
        @(negedge clk);
        src_in[k] = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            #1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #(4 * 50000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        irq_chk(1'b1, "R1 irq_n after reset");
        read_chk(12'h114, 32'h0, "R1 enable word after reset");
        read_chk(12'h000, 32'h40, "R1 control word 0 after reset");
        read_chk(12'h07C, 32'h40, "R1 control word 31 after reset");

        // R2 control field placement
        bus_write(12'h014, 32'hFFFF_FFFF);
        read_chk(12'h014, 32'hC7, "R2 control word 5 fields");
        bus_write(12'h014, 32'h40);
        read_chk(12'h014, 32'h40, "R2 control word 5 restore");

        // R3 enable set/clear command words
        bus_write(12'h120, 32'hF0);
        read_chk(12'h114, 32'hF0, "R3 enable set");
        bus_write(12'h120, 32'h03);
        read_chk(12'h114, 32'hF3, "R3 zero bits keep state");
        bus_write(12'h124, 32'h30);
        read_chk(12'h114, 32'hC3, "R3 enable clear");
        bus_write(12'h124, 32'hFFFF_FFFF);
        read_chk(12'h114, 32'h0, "R3 clear all");

        // R4 / R10 high-level source 4, first disabled
        set_pin(4, 1'b1);
        idle(2);
        irq_chk(1'b1, "R10 disabled source keeps irq_n high");
        read_chk(12'h100, 32'h10, "R4 raw inputs");
        read_chk(12'h104, 32'h10, "R4 pending word");
        read_chk(12'h108, 32'h0, "R10 status excludes disabled");
        bus_write(12'h120, 32'h10);
        idle(2);
        irq_chk(1'b0, "R4 level request");
        read_chk(12'h108, 32'h10, "R4 status word");
        read_chk(12'h110, 32'd4, "R7 source number");
        read_chk(12'h10C, 32'd16, "R7 encoding word");
        irq_chk(1'b1, "R7 read releases request");
        idle(4);
        irq_chk(1'b1, "R8 quiet during service");
        bus_write(12'h130, 32'h0);
        irq_chk(1'b0, "R8 re-raise at once after end-of-service");
        read_chk(12'h10C, 32'd16, "R7 encoding word again");
        set_pin(4, 1'b0);
        bus_write(12'h130, 32'h0);
        idle(1);
        irq_chk(1'b1, "R8 idle after end-of-service");
        bus_write(12'h124, 32'hFFFF_FFFF);

        // R4 low-level source 6
        bus_write(12'h018, 32'h00);
        read_chk(12'h104, 32'h40, "R4 low level pending");
        set_pin(6, 1'b1);
        idle(1);
        read_chk(12'h104, 32'h0, "R4 low level released");

        // R5 rising edge source 9
        bus_write(12'h024, 32'hC2);
        bus_write(12'h120, 32'h200);
        set_pin(9, 1'b1);
        idle(3);
        irq_chk(1'b0, "R5 rising edge request");
        read_chk(12'h104, 32'h200, "R5 rising edge latched");
        read_chk(12'h10C, 32'd36, "R5 encoding of source 9");
        read_chk(12'h104, 32'h0, "R5 acknowledge clears latch");
        bus_write(12'h130, 32'h0);
        idle(2);
        irq_chk(1'b1, "R5 no re-raise with input held high");

        // R5 falling edge source 10, R9 clear
        bus_write(12'h028, 32'h81);
        set_pin(10, 1'b1);
        idle(2);
        read_chk(12'h104, 32'h0, "R5 rising input ignored in falling mode");
        set_pin(10, 1'b0);
        idle(2);
        read_chk(12'h104, 32'h400, "R5 falling edge latched");
        bus_write(12'h12C, 32'h400);
        read_chk(12'h104, 32'h0, "R9 software clear");
        bus_write(12'h124, 32'hFFFF_FFFF);

        // R6 arbitration
        bus_write(12'h00C, 32'h45);
        bus_write(12'h01C, 32'h45);
        bus_write(12'h030, 32'h46);
        bus_write(12'h120, 32'h1088);
        bus_write(12'h128, 32'h88);
        idle(2);
        read_chk(12'h110, 32'd3, "R6 tie goes to lower number");
        read_chk(12'h10C, 32'd12, "R6 encoding of source 3");
        bus_write(12'h130, 32'h0);
        irq_chk(1'b0, "R8 re-raise for source 7");
        bus_write(12'h128, 32'h1000);
        idle(2);
        read_chk(12'h10C, 32'd48, "R6 higher priority displaces winner");
        bus_write(12'h130, 32'h0);
        read_chk(12'h10C, 32'd28, "R6 remaining source 7");
        bus_write(12'h130, 32'h0);
        idle(1);
        irq_chk(1'b1, "R6 all served");
        bus_write(12'h124, 32'hFFFF_FFFF);

        // R9 / R10 software set on disabled source 20
        bus_write(12'h128, 32'h0010_0000);
        idle(2);
        read_chk(12'h104, 32'h0010_0000, "R9 software set");
        read_chk(12'h108, 32'h0, "R10 disabled not in status");
        irq_chk(1'b1, "R10 disabled source silent");
        bus_write(12'h12C, 32'h0010_0000);
        read_chk(12'h104, 32'h0, "R9 software clear of set");

        // R8 end-of-service outside service
        bus_write(12'h130, 32'h0);
        idle(1);
        irq_chk(1'b1, "R8 stray end-of-service ignored");

        idle(2);
        finish_run();
    end

endmodule